// File: doc/BRIEF.md
# Framed Bit-Serial Sample Receiver

This block takes I/Q samples delivered over a three-wire serial link (bit clock, frame strobe, data line) and turns them into parallel words in the core clock domain. The link inputs are asynchronous to the core clock. They pass through a multi-flop synchronizer, and the active bit-clock edge is found by oversampling in the core domain. A frame begins with one bit-clock cycle in which the strobe is active. The data bits follow, most significant first, on the next bit clocks.

Static configuration inputs pick the sampling edge, the strobe polarity and the word format. The format is either one 16-bit word per strobe or a packed 32-bit I-then-Q transfer, used for either real or complex samples. Each finished sample gives a one-cycle valid pulse, and the I and Q outputs hold their value until the next sample. Two error pulses report problems. One is a strobe that never went inactive between frames. The other is a sample request from the core that arrives while the previous request is still unanswered.

Top module: `serial_sample_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_i`, `out_q`, `out_valid`, `frame_err` and `late_err` are zero. Reset also returns the complex 16-bit mode to the I half.
- R2: Strobe and data are taken on rising `ser_clk` edges when `cfg_fall_edge` is 0, and on falling edges when it is 1. Transitions in the other direction have no effect.
- R3: The strobe is active when `ser_frame` is 1 if `cfg_strobe_low` is 0, and active when `ser_frame` is 0 if `cfg_strobe_low` is 1.
- R4: With `cfg_packed32`=0 and `cfg_complex`=0, the 16 data bits that follow the strobe edge appear MSB first on `out_i`, and `out_q` is 0.
- R5: With `cfg_packed32`=0 and `cfg_complex`=1, the first frame supplies I and the next frame supplies Q. No valid pulse appears and the outputs do not change after the first frame. Both words appear together after the second frame.
- R6: With `cfg_packed32`=1 and `cfg_complex`=1, a single strobe starts 32 bits. The first 16 bits go to `out_i` and the last 16 bits go to `out_q`, each MSB first.
- R7: With `cfg_packed32`=1 and `cfg_complex`=0, the first 16 bits of the 32-bit transfer go to `out_i`, and `out_q` is 0.
- R8: A new frame is accepted right after the last data bit of the previous one, provided the strobe was seen inactive on at least one active edge since the previous strobe.
- R9: A strobe seen active on an idle edge without an inactive sample since the previous strobe starts no frame. Instead `frame_err` pulses for one cycle. Strobe levels during data bits never affect the data.
- R10: `out_i` and `out_q` change only in a cycle in which `out_valid` is 1.
- R11: `late_err` pulses for one cycle, in the cycle after a `smp_req` pulse, when the previous `smp_req` has had no `out_valid` since it. The first request after reset never flags.
- R12: `out_valid` is high for exactly one core cycle per completed sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fall_edge | input | 1 | 1: sample on falling bit-clock edges |
| cfg_strobe_low | input | 1 | 1: strobe is active low |
| cfg_packed32 | input | 1 | 1: one strobe per 32-bit I/Q transfer |
| cfg_complex | input | 1 | 1: samples carry both I and Q |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_frame | input | 1 | Serial frame strobe |
| ser_data | input | 1 | Serial data, MSB first |
| smp_req | input | 1 | Core-domain sample request pulse |
| out_i | output | WORD_W | Assembled I word |
| out_q | output | WORD_W | Assembled Q word |
| out_valid | output | 1 | One-cycle pulse when a sample is complete |
| frame_err | output | 1 | Pulse: strobe did not return inactive |
| late_err | output | 1 | Pulse: previous request unanswered |

## Verification
The properties assume several things about the inputs. Each bit-clock level lasts longer than the synchronizer depth plus one core cycle, so active edges are at least two core cycles apart. Data and strobe are steady around the active edge. The configuration changes only while no frame is in flight, and `smp_req` is a single-cycle pulse. The stimulus meets these conditions by holding each bit-clock level for four core cycles. It changes data only on the inactive half-cycle, changes the configuration only between frames with the strobe inactive, and drives requests as one-cycle pulses.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic {FR_IDLE, FR_SHIFT} fr_state_e;

  function automatic int unsigned bits_per_frame(input logic pk32, input int unsigned word_w);
    return pk32 ? 2 * word_w : word_w;
  endfunction
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/ssr_edge.sv
module ssr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_fall_edge,
  input  logic cfg_strobe_low,
  input  logic ser_clk,
  input  logic ser_frame,
  input  logic ser_data,
  output logic bit_stb,
  output logic bit_val,
  output logic frm_act
);
  logic [2:0] raw;
  logic [2:0] syn;
  logic       clk_prev;
  logic       lvl_now;
  logic       lvl_prev;

  assign raw = {ser_clk, ser_frame, ser_data};

  ssr_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (raw),
    .dout(syn)
  );

  always_ff @(posedge clk) begin
    if (rst) clk_prev <= 1'b0;
    else     clk_prev <= syn[2];
  end

  assign lvl_now  = syn[2]   ^ cfg_fall_edge;
  assign lvl_prev = clk_prev ^ cfg_fall_edge;
  assign bit_stb  = lvl_now & ~lvl_prev;
  assign bit_val  = syn[0];
  assign frm_act  = syn[1] ^ cfg_strobe_low;
endmodule

// File: rtl/ssr_framer.sv
module ssr_framer
  import ssr_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_packed32,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              frm_act,
  output logic              done,
  output logic [2*WORD_W-1:0] word,
  output logic              err
);
  localparam int FULL_W = 2 * WORD_W;
  localparam int CNT_W  = $clog2(FULL_W);
  localparam logic [CNT_W-1:0] LAST_PK = CNT_W'(bits_per_frame(1'b1, WORD_W) - 1);
  localparam logic [CNT_W-1:0] LAST_SG = CNT_W'(bits_per_frame(1'b0, WORD_W) - 1);

  fr_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [FULL_W-1:0] sr;
  logic              armed;
  logic [CNT_W-1:0]  last_idx;

  assign last_idx = cfg_packed32 ? LAST_PK : LAST_SG;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_IDLE;
      cnt   <= '0;
      sr    <= '0;
      armed <= 1'b0;
      done  <= 1'b0;
      err   <= 1'b0;
      word  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (bit_stb) begin
        unique case (state)
          FR_IDLE: begin
            if (frm_act && armed) begin
              state <= FR_SHIFT;
              cnt   <= '0;
              armed <= 1'b0;
            end else if (frm_act) begin
              err <= 1'b1;
            end else begin
              armed <= 1'b1;
            end
          end
          FR_SHIFT: begin
            if (!frm_act) armed <= 1'b1;
            sr <= {sr[FULL_W-2:0], bit_val};
            if (cnt == last_idx) begin
              state <= FR_IDLE;
              done  <= 1'b1;
              word  <= {sr[FULL_W-2:0], bit_val};
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ssr_assembler.sv
module ssr_assembler #(
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_packed32,
  input  logic                cfg_complex,
  input  logic                done,
  input  logic [2*WORD_W-1:0] word,
  output logic [WORD_W-1:0]   out_i,
  output logic [WORD_W-1:0]   out_q,
  output logic                out_valid
);
  logic [WORD_W-1:0] i_hold;
  logic              q_phase;
  logic [WORD_W-1:0] hi_w;
  logic [WORD_W-1:0] lo_w;

  assign hi_w = word[2*WORD_W-1:WORD_W];
  assign lo_w = word[WORD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_i     <= '0;
      out_q     <= '0;
      out_valid <= 1'b0;
      i_hold    <= '0;
      q_phase   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (done) begin
        if (cfg_packed32) begin
          out_i     <= hi_w;
          out_q     <= cfg_complex ? lo_w : '0;
          out_valid <= 1'b1;
        end else if (!cfg_complex) begin
          out_i     <= lo_w;
          out_q     <= '0;
          out_valid <= 1'b1;
        end else if (!q_phase) begin
          i_hold  <= lo_w;
          q_phase <= 1'b1;
        end else begin
          out_i     <= i_hold;
          out_q     <= lo_w;
          out_valid <= 1'b1;
          q_phase   <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ssr_deadline.sv
module ssr_deadline (
  input  logic clk,
  input  logic rst,
  input  logic smp_req,
  input  logic served_now,
  output logic late_err
);
  logic pending;
  logic served;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      served   <= 1'b0;
      late_err <= 1'b0;
    end else begin
      late_err <= 1'b0;
      if (smp_req) begin
        if (pending && !served && !served_now) late_err <= 1'b1;
        pending <= 1'b1;
        served  <= 1'b0;
      end else if (served_now) begin
        served <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_sample_rx.sv
module serial_sample_rx #(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_fall_edge,
  input  logic              cfg_strobe_low,
  input  logic              cfg_packed32,
  input  logic              cfg_complex,
  input  logic              ser_clk,
  input  logic              ser_frame,
  input  logic              ser_data,
  input  logic              smp_req,
  output logic [WORD_W-1:0] out_i,
  output logic [WORD_W-1:0] out_q,
  output logic              out_valid,
  output logic              frame_err,
  output logic              late_err
);
  logic                bit_stb;
  logic                bit_val;
  logic                frm_act;
  logic                fr_done;
  logic [2*WORD_W-1:0] fr_word;

  ssr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk           (clk),
    .rst           (rst),
    .cfg_fall_edge (cfg_fall_edge),
    .cfg_strobe_low(cfg_strobe_low),
    .ser_clk       (ser_clk),
    .ser_frame     (ser_frame),
    .ser_data      (ser_data),
    .bit_stb       (bit_stb),
    .bit_val       (bit_val),
    .frm_act       (frm_act)
  );

  ssr_framer #(.WORD_W(WORD_W)) u_framer (
    .clk         (clk),
    .rst         (rst),
    .cfg_packed32(cfg_packed32),
    .bit_stb     (bit_stb),
    .bit_val     (bit_val),
    .frm_act     (frm_act),
    .done        (fr_done),
    .word        (fr_word),
    .err         (frame_err)
  );

  ssr_assembler #(.WORD_W(WORD_W)) u_asm (
    .clk         (clk),
    .rst         (rst),
    .cfg_packed32(cfg_packed32),
    .cfg_complex (cfg_complex),
    .done        (fr_done),
    .word        (fr_word),
    .out_i       (out_i),
    .out_q       (out_q),
    .out_valid   (out_valid)
  );

  ssr_deadline u_dl (
    .clk       (clk),
    .rst       (rst),
    .smp_req   (smp_req),
    .served_now(out_valid),
    .late_err  (late_err)
  );
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_complex,
  input logic              smp_req,
  input logic [WORD_W-1:0] out_i,
  input logic [WORD_W-1:0] out_q,
  input logic              out_valid,
  input logic              frame_err,
  input logic              late_err
);
  a_r12_valid_single: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r10_hold_outputs: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));

  a_r4_real_q_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_complex) |-> (out_q == '0));

  a_r9_err_single: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  a_r11_late_after_req: assert property (@(posedge clk) disable iff (rst)
    late_err |-> $past(smp_req));
endmodule

bind serial_sample_rx ssr_checker #(.WORD_W(WORD_W)) u_ssr_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_complex(cfg_complex),
  .smp_req    (smp_req),
  .out_i      (out_i),
  .out_q      (out_q),
  .out_valid  (out_valid),
  .frame_err  (frame_err),
  .late_err   (late_err)
);

// File: tb/serial_sample_rx_test.sv
module serial_sample_rx_test;
  localparam int W  = 16;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_fall_edge = 1'b0, cfg_strobe_low = 1'b0, cfg_packed32 = 1'b0, cfg_complex = 1'b0;
  logic ser_clk = 1'b0, ser_frame = 1'b0, ser_data = 1'b0, smp_req = 1'b0;
  logic [W-1:0] out_i, out_q;
  logic out_valid, frame_err, late_err;

  int checks = 0, errors = 0;
  int cap_n = 0, err_n = 0, late_n = 0, wide_n = 0;
  logic [W-1:0] cap_i [32];
  logic [W-1:0] cap_q [32];
  logic prev_v = 1'b0;

  always #10 clk = ~clk;

  serial_sample_rx #(.WORD_W(W)) uut (
    .clk(clk), .rst(rst), .cfg_fall_edge(cfg_fall_edge), .cfg_strobe_low(cfg_strobe_low),
    .cfg_packed32(cfg_packed32), .cfg_complex(cfg_complex), .ser_clk(ser_clk),
    .ser_frame(ser_frame), .ser_data(ser_data), .smp_req(smp_req), .out_i(out_i),
    .out_q(out_q), .out_valid(out_valid), .frame_err(frame_err), .late_err(late_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        cap_i[cap_n % 32] = out_i;
        cap_q[cap_n % 32] = out_q;
        cap_n++;
        if (prev_v) wide_n++;
      end
      if (frame_err) err_n++;
      if (late_err) late_n++;
    end
    prev_v = out_valid;
  end

  // {fall, strobe_low, packed32, complex, I, Q}
  localparam logic [35:0] VEC [7] = '{
    {4'b0000, 16'hA5C3, 16'h0000},
    {4'b1000, 16'h8001, 16'h0000},
    {4'b0101, 16'h1234, 16'hABCD},
    {4'b1111, 16'hFFFF, 16'h0001},
    {4'b0010, 16'h7E81, 16'h5555},
    {4'b0011, 16'h0F0F, 16'hF0F0},
    {4'b1001, 16'h0000, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_cycle(input logic act, input logic d);
    ser_frame = act ^ cfg_strobe_low;
    ser_data  = d;
    cyc(HP);
    ser_clk = ~cfg_fall_edge;
    cyc(HP);
    ser_clk = cfg_fall_edge;
  endtask

  task automatic send_frame(input int nbits, input logic [31:0] w, input bit pre, input bit hold);
    if (pre) bit_cycle(1'b0, 1'b0);
    bit_cycle(1'b1, 1'b0);
    for (int b = nbits - 1; b >= 0; b--) bit_cycle(hold, w[b]);
    ser_frame = cfg_strobe_low;
  endtask

  task automatic set_cfg(input logic [3:0] c);
    {cfg_fall_edge, cfg_strobe_low, cfg_packed32, cfg_complex} = c;
    ser_clk = c[3];
    ser_frame = c[2];
    cyc(6);
  endtask

  task automatic pulse_req();
    smp_req = 1'b1;
    cyc(1);
    smp_req = 1'b0;
    cyc(3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(4);
    chk("R1 reset out_i", 32'(out_i), 0);
    chk("R1 reset valid/err", {29'd0, out_valid, frame_err, late_err}, 0);
    rst = 1'b0;
    cyc(1);
    chk("R1 after reset", {out_i, out_q}, 0);

    // table-driven main function: R2 R3 R4 R5 R6 R7 R10 R12
    for (int v = 0; v < 7; v++) begin
      logic [3:0] c;
      logic [W-1:0] ei, eq;
      int n0;
      c  = VEC[v][35:32];
      ei = VEC[v][31:16];
      eq = c[0] ? VEC[v][15:0] : '0;
      set_cfg(c);
      n0 = cap_n;
      if (c[1]) begin
        send_frame(32, VEC[v][31:0], 1, 0);
      end else if (c[0]) begin
        logic [W-1:0] prev_i;
        prev_i = out_i;
        send_frame(16, {16'h0, ei}, 1, 0);
        cyc(12);
        chk("R5 no valid after I half", 32'(cap_n), 32'(n0));
        chk("R5 outputs unchanged after I half", 32'(out_i), 32'(prev_i));
        send_frame(16, {16'h0, VEC[v][15:0]}, 0, 0);
      end else begin
        send_frame(16, {16'h0, ei}, 1, 0);
      end
      cyc(12);
      chk($sformatf("R2/R3/R4-R7 vec %0d count", v), 32'(cap_n), 32'(n0 + 1));
      chk($sformatf("R4/R6/R7 vec %0d word", v), {cap_i[(cap_n + 31) % 32], cap_q[(cap_n + 31) % 32]}, {ei, eq});
      cyc(20);
      chk($sformatf("R10 vec %0d held", v), {out_i, out_q}, {ei, eq});
    end
    chk("R12 valid one cycle", 32'(wide_n), 0);

    // R8 back-to-back frames
    set_cfg(4'b0000);
    begin
      int n0;
      n0 = cap_n;
      send_frame(16, 32'h0000_1111, 1, 0);
      send_frame(16, 32'h0000_2222, 0, 0);
      cyc(12);
      chk("R8 two frames accepted", 32'(cap_n), 32'(n0 + 2));
      chk("R8 first word", 32'(cap_i[(n0) % 32]), 32'h1111);
      chk("R8 second word", 32'(cap_i[(n0 + 1) % 32]), 32'h2222);
    end

    // R9 strobe held active: data intact, no new frame, error pulse
    begin
      int n0, e0;
      n0 = cap_n;
      e0 = err_n;
      send_frame(16, 32'h0000_C3C3, 1, 1);
      bit_cycle(1'b1, 1'b1);
      bit_cycle(1'b1, 1'b0);
      ser_frame = 1'b0;
      cyc(12);
      chk("R9 first frame delivered", 32'(cap_n), 32'(n0 + 1));
      chk("R9 word ignores strobe during data", 32'(out_i), 32'hC3C3);
      chk("R9 frame_err pulses", 32'(err_n - e0), 2);
      send_frame(16, 32'h0000_0F0F, 1, 0);
      cyc(12);
      chk("R9 recovery frame", {out_i, 16'(cap_n - n0)}, {16'h0F0F, 16'd2});
    end

    // R11 late request detection
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(2);
    chk("R1 reset clears outputs", {out_i, out_q}, 0);
    begin
      int l0;
      l0 = late_n;
      pulse_req();
      chk("R11 first request no flag", 32'(late_n - l0), 0);
      pulse_req();
      chk("R11 unanswered request flags", 32'(late_n - l0), 1);
      send_frame(16, 32'h0000_ABCD, 1, 0);
      cyc(12);
      pulse_req();
      chk("R11 answered request no flag", 32'(late_n - l0), 1);
    end

    // R1 reset clears complex phase: I half, reset, then full pair
    set_cfg(4'b0001);
    send_frame(16, 32'h0000_DEAD, 1, 0);
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(2);
    send_frame(16, 32'h0000_1357, 1, 0);
    send_frame(16, 32'h0000_2468, 0, 0);
    cyc(12);
    chk("R1/R5 phase restarts at I", {out_i, out_q}, 32'h1357_2468);
    chk("R12 valid one cycle final", 32'(wide_n), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule